// File: doc/BRIEF.md
# Serial Interrupt Bus Host Controller

This block is the host end of a single-wire serialized interrupt bus that runs on the bus clock. The host opens every serial cycle with a start frame. It then steps through a configurable number of interrupt/data frames, and in the first clock of each frame it samples the level that peripherals put on the wire. It closes the cycle with a stop pulse. The length of that pulse tells every agent how the next cycle begins. In continuous mode the host restarts on its own. In quiet mode the bus stays idle until a peripheral pulls it low, and the host then completes the start frame.

The wire is open-drain. The block drives it through `bus_drive_low` and reads it back on `bus_in`. Only the host ever produces a stop pulse. After reset the host runs one cycle at once to gather the default levels, whatever mode is selected. The mode request is sampled at the end of the last frame and sets the length of that cycle's stop pulse. To park the bus before a suspend or a configuration change, software selects continuous mode. With continuous mode selected, the idle bus is always followed by a host-started cycle.

The state machine has seven states. BOOT is the first clock after reset. START drives the start frame low. TURN is the released turnaround clock. FRAME walks the frames in phases sample, recovery and turnaround. STOP drives the stop pulse low. RECOV is the first released clock after the stop pulse. IDLE waits for the next cycle. The transitions are:
- BOOT goes to START.
- START goes to TURN after its last low clock.
- TURN goes to FRAME.
- FRAME loops through its phases and frames, then goes to STOP after the last frame's turnaround.
- STOP goes to RECOV after 2 clocks in quiet mode or 3 clocks in continuous mode.
- RECOV goes to IDLE.
- IDLE goes to START after one clock in continuous mode. In quiet mode it goes to START on a sampled low bus, skipping the first start clock.

Top module: `sirq_host_ctrl`

## Requirements
- R1: While `rst` is high, `bus_drive_low` is 0 at once (asynchronous reset), and `irq_levels` is cleared to all zeros, also at a reset asserted in the middle of a cycle.
- R2: In the first clock after `rst` falls, the host drives the bus low and begins a start frame, even when `mode_quiet` is 1.
- R3: A host-started start frame is 4 consecutive clocks with `bus_drive_low`=1, followed by one turnaround clock with it at 0.
- R4: The number of frames N is `frame_count` clamped to the range 17..MAX_FRAMES, latched on the clock edge that enters the start frame. Each frame lasts 3 clocks, with `bus_drive_low`=0 throughout, and the stop pulse begins right after the N-th frame.
- R5: Bit i of `irq_levels` becomes 1 if `bus_in` is 0 at the rising edge that ends the first clock of frame i, and 0 otherwise. Bits N and above keep their previous values.
- R6: `mode_quiet` is sampled on the rising edge that ends the last frame. The stop pulse is then 2 low clocks if it was 1 (quiet) and 3 low clocks if it was 0 (continuous). A change of `mode_quiet` at any other time does not alter that stop pulse.
- R7: After a continuous stop pulse the bus is released for exactly 2 clocks, and then the host starts a 4-clock start frame. A low on `bus_in` during those released clocks changes nothing.
- R8: After a quiet stop pulse the host keeps the bus released indefinitely. A low on `bus_in` in the first released clock is ignored. A low sampled on any later idle clock makes the host drive low for the next 3 clocks, followed by one turnaround clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all driving and sampling on its rising edge |
| rst | input | 1 | Active-high asynchronous reset |
| bus_in | input | 1 | Sampled level of the serial bus wire (0 = low) |
| mode_quiet | input | 1 | Mode request for the next cycle: 1 quiet, 0 continuous |
| frame_count | input | $clog2(MAX_FRAMES+1) | Requested frames per cycle, clamped to 17..MAX_FRAMES |
| bus_drive_low | output | 1 | 1 pulls the bus wire low, 0 releases it |
| irq_levels | output | MAX_FRAMES | Collected frame levels, 1 = asserted (bus sampled low) |

## Verification
The bench builds the block with MAX_FRAMES=24, which gives `frame_count` a 5-bit port. Requests of 0 and 31 therefore reach both clamp limits, and exactly 17 and 24 exercise the edges. The short maximum keeps each cycle under 90 clocks, so about twenty cycles fit, with random modes, random levels and random quiet idle lengths. Directed cases cover a peripheral low in the first clock after a quiet stop, a low in the continuous idle clock, mode flips just before and just after the sampling edge, and a reset in the middle of a start frame.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_START,
        ST_TURN,
        ST_FRAME,
        ST_STOP,
        ST_RECOV,
        ST_IDLE
    } sirq_state_e;

    localparam int MIN_FRAMES  = 17;
    localparam int START_SLOTS = 4;
    localparam int FRAME_SLOTS = 3;
    localparam int STOP_QUIET  = 2;
    localparam int STOP_CONT   = 3;

endpackage

// File: rtl/sirq_cfg_latch.sv
module sirq_cfg_latch
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 32,
    parameter int CW         = $clog2(MAX_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_cnt,
    input  logic          load_mode,
    input  logic [CW-1:0] frame_count,
    input  logic          mode_quiet,
    output logic [CW-1:0] n_frames,
    output logic          quiet_q
);

    localparam logic [CW-1:0] LO_LIM = CW'(MIN_FRAMES);
    localparam logic [CW-1:0] HI_LIM = CW'(MAX_FRAMES);

    logic [CW-1:0] clamped;

    always_comb begin
        if (frame_count < LO_LIM) begin
            clamped = LO_LIM;
        end else if (frame_count > HI_LIM) begin
            clamped = HI_LIM;
        end else begin
            clamped = frame_count;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            n_frames <= LO_LIM;
            quiet_q  <= 1'b0;
        end else begin
            if (load_cnt) begin
                n_frames <= clamped;
            end
            if (load_mode) begin
                quiet_q <= mode_quiet;
            end
        end
    end

    // R4
    frames_range_chk: assert property (@(posedge clk) disable iff (rst)
        (n_frames >= LO_LIM) && (n_frames <= HI_LIM));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(quiet_q) |-> $past(load_mode));

endmodule

// File: rtl/sirq_fsm.sv
module sirq_fsm
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 32,
    parameter int CW         = $clog2(MAX_FRAMES + 1),
    parameter int IW         = $clog2(MAX_FRAMES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_in,
    input  logic [CW-1:0] n_frames,
    input  logic          quiet_q,
    output logic          drive_low,
    output logic          load_cnt,
    output logic          load_mode,
    output logic          sample_en,
    output logic [IW-1:0] sample_idx
);

    localparam logic [1:0] START_LAST = 2'(START_SLOTS - 1);
    localparam logic [1:0] FRAME_LAST = 2'(FRAME_SLOTS - 1);
    localparam logic [1:0] QSTOP_LAST = 2'(STOP_QUIET - 1);
    localparam logic [1:0] CSTOP_LAST = 2'(STOP_CONT - 1);

    sirq_state_e   st, st_nx;
    logic [1:0]    cnt, cnt_nx;
    logic [IW-1:0] fidx, fidx_nx;
    logic          last_frame;
    logic [1:0]    stop_last;

    assign last_frame = (CW'(fidx) == (n_frames - CW'(1)));
    assign stop_last  = quiet_q ? QSTOP_LAST : CSTOP_LAST;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st   <= ST_BOOT;
            cnt  <= '0;
            fidx <= '0;
        end else begin
            st   <= st_nx;
            cnt  <= cnt_nx;
            fidx <= fidx_nx;
        end
    end

    always_comb begin
        st_nx     = st;
        cnt_nx    = cnt;
        fidx_nx   = fidx;
        load_cnt  = 1'b0;
        load_mode = 1'b0;
        unique case (st)
            ST_BOOT: begin
                st_nx    = ST_START;
                cnt_nx   = '0;
                load_cnt = 1'b1;
            end
            ST_START: begin
                if (cnt == START_LAST) begin
                    st_nx  = ST_TURN;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 2'd1;
                end
            end
            ST_TURN: begin
                st_nx   = ST_FRAME;
                cnt_nx  = '0;
                fidx_nx = '0;
            end
            ST_FRAME: begin
                if (cnt == FRAME_LAST) begin
                    cnt_nx = '0;
                    if (last_frame) begin
                        st_nx     = ST_STOP;
                        load_mode = 1'b1;
                    end else begin
                        fidx_nx = fidx + IW'(1);
                    end
                end else begin
                    cnt_nx = cnt + 2'd1;
                end
            end
            ST_STOP: begin
                if (cnt == stop_last) begin
                    st_nx  = ST_RECOV;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 2'd1;
                end
            end
            ST_RECOV: begin
                st_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (!quiet_q) begin
                    st_nx    = ST_START;
                    cnt_nx   = '0;
                    load_cnt = 1'b1;
                end else if (!bus_in) begin
                    st_nx    = ST_START;
                    cnt_nx   = 2'd1;
                    load_cnt = 1'b1;
                end
            end
            default: begin
                st_nx = ST_BOOT;
            end
        endcase
    end

    always_comb begin
        drive_low  = 1'b0;
        sample_en  = 1'b0;
        sample_idx = fidx;
        unique case (st)
            ST_START: drive_low = 1'b1;
            ST_STOP:  drive_low = 1'b1;
            ST_FRAME: sample_en = (cnt == 2'd0);
            default: begin
                drive_low = 1'b0;
                sample_en = 1'b0;
            end
        endcase
    end

    logic [2:0] stop_run;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stop_run <= '0;
        end else if (st == ST_STOP) begin
            stop_run <= stop_run + 3'd1;
        end else begin
            stop_run <= '0;
        end
    end

    // R3
    start_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TURN) |-> ($past(st) == ST_START && $past(st, 3) == ST_START));

    // R6
    stop_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECOV) |-> (stop_run == (quiet_q ? 3'(STOP_QUIET) : 3'(STOP_CONT))));

    // R7
    cont_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !quiet_q) |=> (st == ST_START));

    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && quiet_q && bus_in) |=> (st == ST_IDLE && !drive_low));

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
    parameter int MAX_FRAMES = 32,
    parameter int IW         = $clog2(MAX_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample_en,
    input  logic [IW-1:0]         sample_idx,
    input  logic                  bus_in,
    output logic [MAX_FRAMES-1:0] irq_levels
);

    for (genvar g = 0; g < MAX_FRAMES; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (sample_en && (sample_idx == IW'(g))) begin
                bit_q <= ~bus_in;
            end
        end
        assign irq_levels[g] = bit_q;
    end

endmodule

// File: rtl/sirq_host_ctrl.sv
module sirq_host_ctrl
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 32,
    parameter int CW         = $clog2(MAX_FRAMES + 1),
    parameter int IW         = $clog2(MAX_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_in,
    input  logic                  mode_quiet,
    input  logic [CW-1:0]         frame_count,
    output logic                  bus_drive_low,
    output logic [MAX_FRAMES-1:0] irq_levels
);

    logic          load_cnt;
    logic          load_mode;
    logic          quiet_q;
    logic          sample_en;
    logic [CW-1:0] n_frames;
    logic [IW-1:0] sample_idx;

    sirq_cfg_latch #(.MAX_FRAMES(MAX_FRAMES), .CW(CW)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .load_cnt    (load_cnt),
        .load_mode   (load_mode),
        .frame_count (frame_count),
        .mode_quiet  (mode_quiet),
        .n_frames    (n_frames),
        .quiet_q     (quiet_q)
    );

    sirq_fsm #(.MAX_FRAMES(MAX_FRAMES), .CW(CW), .IW(IW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bus_in     (bus_in),
        .n_frames   (n_frames),
        .quiet_q    (quiet_q),
        .drive_low  (bus_drive_low),
        .load_cnt   (load_cnt),
        .load_mode  (load_mode),
        .sample_en  (sample_en),
        .sample_idx (sample_idx)
    );

    sirq_capture #(.MAX_FRAMES(MAX_FRAMES), .IW(IW)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .sample_idx (sample_idx),
        .bus_in     (bus_in),
        .irq_levels (irq_levels)
    );

    // R1
    release_in_reset_chk: assert property (@(posedge clk)
        rst |-> !bus_drive_low);

    // R4
    sample_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> (CW'(sample_idx) < n_frames));

endmodule

// File: tb/tb_sirq_host_ctrl.sv
`timescale 1ns/1ps
module tb_sirq_host_ctrl;

    localparam int MAXF = 24;
    localparam int CW   = $clog2(MAXF + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            periph_low = 1'b0;
    logic            mode_quiet = 1'b1;
    logic [CW-1:0]   frame_count = '0;
    logic            bus_drive_low;
    logic [MAXF-1:0] irq_levels;
    logic            bus_in;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [MAXF-1:0] prev_lv = '0;

    assign bus_in = ~(bus_drive_low | periph_low);

    always #4 clk = ~clk;

    sirq_host_ctrl #(.MAX_FRAMES(MAXF)) dut (
        .clk           (clk),
        .rst           (rst),
        .bus_in        (bus_in),
        .mode_quiet    (mode_quiet),
        .frame_count   (frame_count),
        .bus_drive_low (bus_drive_low),
        .irq_levels    (irq_levels)
    );

    function automatic int eff_frames(input int fc);
        if (fc < 17) return 17;
        if (fc > MAXF) return MAXF;
        return fc;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Entered at the negedge inside the first host-driven start clock.
    // Returns at the negedge inside the first idle clock.
    task automatic do_cycle(input logic [MAXF-1:0] lv, input int fc, input bit q,
                            input int start_len, input bit poke_recov);
        int n = eff_frames(fc);
        int bad;
        int stop_len = q ? 2 : 3;
        logic [MAXF-1:0] expv = prev_lv;
        mode_quiet = ~q;
        bad = 0;
        for (int k = 0; k < start_len; k++) begin
            if (!bus_drive_low) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R3", "start frame low clocks missing", bad, 0);
        chk(!bus_drive_low, "R3", "turnaround released", bus_drive_low, 0);
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            periph_low = lv[i];
            if (bus_drive_low) bad++;
            @(negedge clk);
            periph_low = 1'b0;
            if (bus_drive_low) bad++;
            @(negedge clk);
            if (bus_drive_low) bad++;
            if (i == n - 1) mode_quiet = q;
            @(negedge clk);
        end
        chk(bad == 0, "R4", "host drove during frames", bad, 0);
        mode_quiet = ~q;
        bad = 0;
        for (int k = 0; k < stop_len; k++) begin
            if (!bus_drive_low) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R6", "stop pulse low clocks missing", bad, 0);
        chk(!bus_drive_low, "R6", "stop pulse too long", bus_drive_low, 0);
        for (int i = 0; i < n; i++) expv[i] = lv[i];
        chk(irq_levels == expv, "R5", "collected levels", irq_levels, expv);
        prev_lv = expv;
        if (poke_recov) periph_low = 1'b1;
        @(negedge clk);
        periph_low = 1'b0;
        chk(!bus_drive_low, q ? "R8" : "R7", "released in idle", bus_drive_low, 0);
    endtask

    // Ends at the negedge inside the first host-driven start clock.
    task automatic launch(input bit q_prev, input int fc, input bit poke_idle,
                          input int wait_n, output int start_len);
        frame_count = CW'(fc);
        if (!q_prev) begin
            if (poke_idle) periph_low = 1'b1;
            @(negedge clk);
            periph_low = 1'b0;
            chk(bus_drive_low, "R7", "continuous restart", bus_drive_low, 1);
            start_len = 4;
        end else begin
            int bad = 0;
            for (int k = 0; k < wait_n; k++) begin
                @(negedge clk);
                if (bus_drive_low) bad++;
            end
            chk(bad == 0, "R8", "quiet bus started by host", bad, 0);
            periph_low = 1'b1;
            @(negedge clk);
            periph_low = 1'b0;
            chk(bus_drive_low, "R8", "host completes peripheral start", bus_drive_low, 1);
            start_len = 3;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int sl;
        bit q, qp, pr;
        int fc;
        logic [MAXF-1:0] lv;
        int dir_fc[4] = '{0, 31, 17, 24};
        bit dir_q[4]  = '{0, 1, 1, 0};
        void'($urandom(32'd20240611));

        frame_count = CW'(20);
        repeat (3) @(negedge clk);
        chk(!bus_drive_low, "R1", "released in reset", bus_drive_low, 0);
        chk(irq_levels == '0, "R1", "levels cleared", irq_levels, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_drive_low, "R2", "initial cycle start with quiet requested", bus_drive_low, 1);
        fc = 20;
        sl = 4;
        qp = 0;
        for (int c = 0; c < 22; c++) begin
            if (c < 4) begin
                q = dir_q[c];
            end else begin
                q = $urandom_range(0, 1);
            end
            pr = q && ((c == 1) || ($urandom_range(0, 2) == 0));
            lv = MAXF'($urandom());
            do_cycle(lv, fc, q, sl, pr);
            qp = q;
            fc = (c < 4) ? dir_fc[c] : $urandom_range(0, 31);
            launch(qp, fc, (c == 0) || ($urandom_range(0, 1) == 1),
                   $urandom_range(0, 5), sl);
        end

        rst = 1'b1;
        #1;
        chk(!bus_drive_low, "R1", "released at once on mid-cycle reset", bus_drive_low, 0);
        chk(irq_levels == '0, "R1", "levels cleared mid-cycle", irq_levels, 0);
        prev_lv = '0;
        mode_quiet = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_drive_low, "R2", "restart after mid-cycle reset", bus_drive_low, 1);
        lv = MAXF'($urandom());
        do_cycle(lv, fc, 0, 4, 0);
        summary();
    end

endmodule